// File: doc/BRIEF.md
# Coin Accumulating Vending Controller

This block counts the value of coins dropped into a vending slot and raises a release strobe once the deposit reaches the price of 15 units. Two coin sensors are attached: one for 5-unit coins (nickels) and one for 10-unit coins (dimes). Each sensor line is asynchronous to the controller clock and stays high for several cycles while a coin passes. The controller brings each line into the clock domain and turns the first sampled high level into a single-cycle coin event.

The coin events drive a five-level Moore machine that holds the credit at 0, 5, 10, 15 or 20 units. The 15 and 20 levels are each held for exactly one cycle, and the release strobe is high during that cycle. After 15 the credit returns to zero. After 20 the machine keeps the 5-unit overpayment as credit for the next sale. The block does not return change.

Two parameters are available. `EXTRA_SYNC` adds synchronizer flops ahead of the edge detector. `ONE_HOT` selects a binary or a one-hot state register. The behaviour at the ports is the same for either encoding.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the release strobe is 0 and the credit is zero. Reset also clears every synchronizer stage.
- R2: A sense line held high for any number of cycles (at least two) counts as exactly one coin. Its internal coin event lasts one cycle.
- R3: Suppose the sense line of the coin that completes a sale is first sampled high at rising edge k. The release strobe is then high in the cycle after edge k+1+EXTRA_SYNC, and in no earlier cycle.
- R4: A nickel adds 5 units and a dime adds 10 units. Each of the sequences nickel-nickel-nickel, nickel-dime and dime-nickel produces exactly one release.
- R5: The release strobe is high for exactly one cycle per sale. After a 15-unit sale the credit is zero.
- R6: A deposit that reaches 20 units gives one one-cycle release and leaves 5 units of credit, so that a single following dime produces another release.
- R7: A coin event that arrives in the cycle in which the release strobe is high is discarded. It adds no credit.
- R8: When no coin arrives, the credit is held for any number of cycles.
- R9: With ONE_HOT=0 (binary state register) and with ONE_HOT=1 (one-hot state register), the block behaves identically at its ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel_sense | input | 1 | Asynchronous 5-unit coin sensor level |
| coin_dime_sense | input | 1 | Asynchronous 10-unit coin sensor level |
| release_o | output | 1 | One-cycle release strobe at 15 or 20 units |

## Verification
The bench builds two copies side by side from the same sense stimulus. The first uses EXTRA_SYNC=0 with a binary state register. The second uses EXTRA_SYNC=1 with a one-hot register. Running the same stimulus through both compares the two encodings, and the one-cycle difference in synchronizer depth makes the exact latency rule visible on a single edge. Overlapping sense pulses make a coin event fall into the release cycle, and long hold and idle periods cover the single-count and credit-hold rules.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

   // credit levels of the accumulator; 15 and 20 are the release levels
   typedef enum logic [2:0] {
      LV_ZERO    = 3'd0,
      LV_FIVE    = 3'd1,
      LV_TEN     = 3'd2,
      LV_FIFTEEN = 3'd3,
      LV_TWENTY  = 3'd4
   } level_e;

   localparam int NUM_LEVELS = 5;

   // next credit level for the binary register variant
   function automatic level_e next_level(level_e cur, logic nick, logic dime);
      level_e nxt;
      case (cur)
         LV_ZERO:    nxt = dime ? LV_TEN     : (nick ? LV_FIVE    : LV_ZERO);
         LV_FIVE:    nxt = dime ? LV_FIFTEEN : (nick ? LV_TEN     : LV_FIVE);
         LV_TEN:     nxt = dime ? LV_TWENTY  : (nick ? LV_FIFTEEN : LV_TEN);
         LV_FIFTEEN: nxt = LV_ZERO;
         LV_TWENTY:  nxt = LV_FIVE;
         default:    nxt = LV_ZERO;
      endcase
      return nxt;
   endfunction

   function automatic logic is_release(level_e lv);
      return (lv == LV_FIFTEEN) || (lv == LV_TWENTY);
   endfunction

endpackage

// File: rtl/coin_pulse.sv
module coin_pulse #(
   parameter int EXTRA_SYNC = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic sense,
   output logic pulse
);
   localparam int CHAIN = EXTRA_SYNC + 2;

   if (EXTRA_SYNC < 0 || EXTRA_SYNC > 4) begin : g_bad_sync
      $error("coin_pulse: EXTRA_SYNC must lie in 0..4");
   end

   logic [CHAIN-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[CHAIN-2:0], sense};
   end

   // newest detector stage high, older stage still low
   assign pulse = stg[CHAIN-2] & ~stg[CHAIN-1];

endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
   import coin_vend_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   nick,
   input  logic   dime,
   output level_e level,
   output logic   release_o
);
   if (ONE_HOT) begin : g_hot
      localparam int B_Z = 0, B_5 = 1, B_10 = 2, B_15 = 3, B_20 = 4;
      logic [NUM_LEVELS-1:0] hot, hot_nxt;
      logic                  idle;

      assign idle = ~nick & ~dime;

      always_comb begin
         hot_nxt[B_Z]  = (hot[B_Z]  & idle) | hot[B_15];
         hot_nxt[B_5]  = (hot[B_5]  & idle) | (hot[B_Z] & nick) | hot[B_20];
         hot_nxt[B_10] = (hot[B_10] & idle) | (hot[B_Z] & dime) | (hot[B_5] & nick);
         hot_nxt[B_15] = (hot[B_5]  & dime) | (hot[B_10] & nick);
         hot_nxt[B_20] =  hot[B_10] & dime;
      end

      always_ff @(posedge clk) begin
         if (rst || $countones(hot) != 1) hot <= NUM_LEVELS'(1);
         else                             hot <= hot_nxt;
      end

      always_comb begin
         if      (hot[B_20]) level = LV_TWENTY;
         else if (hot[B_15]) level = LV_FIFTEEN;
         else if (hot[B_10]) level = LV_TEN;
         else if (hot[B_5])  level = LV_FIVE;
         else                level = LV_ZERO;
      end

      assign release_o = hot[B_15] | hot[B_20];
   end else begin : g_bin
      level_e cur;

      always_ff @(posedge clk) begin
         if (rst) cur <= LV_ZERO;
         else     cur <= next_level(cur, nick, dime);
      end

      assign level     = cur;
      assign release_o = is_release(cur);
   end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
   import coin_vend_pkg::*;
#(
   parameter int EXTRA_SYNC = 0,
   parameter bit ONE_HOT    = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic coin_nickel_sense,
   input  logic coin_dime_sense,
   output logic release_o
);
   logic   nick_pulse;
   logic   dime_pulse;
   logic   nick_only;
   level_e level;

   coin_pulse #(.EXTRA_SYNC(EXTRA_SYNC)) u_nick (
      .clk   (clk),
      .rst   (rst),
      .sense (coin_nickel_sense),
      .pulse (nick_pulse)
   );

   coin_pulse #(.EXTRA_SYNC(EXTRA_SYNC)) u_dime (
      .clk   (clk),
      .rst   (rst),
      .sense (coin_dime_sense),
      .pulse (dime_pulse)
   );

   // both events together cannot occur; the dime is taken if they do
   assign nick_only = nick_pulse & ~dime_pulse;

   coin_vend_fsm #(.ONE_HOT(ONE_HOT)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .nick      (nick_only),
      .dime      (dime_pulse),
      .level     (level),
      .release_o (release_o)
   );

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk
   import coin_vend_pkg::*;
(
   input logic   clk,
   input logic   rst,
   input logic   release_o,
   input logic   nick_p,
   input logic   dime_p,
   input level_e level
);
   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (level == LV_ZERO && !release_o)); // R1

   AST_NICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      nick_p |=> !nick_p); // R2

   AST_DIME_SINGLE: assert property (@(posedge clk) disable iff (rst)
      dime_p |=> !dime_p); // R2

   AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(release_o) |-> $past(nick_p || dime_p)); // R3

   AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (rst)
      release_o |=> !release_o); // R5

   AST_CARRY_FIVE: assert property (@(posedge clk) disable iff (rst)
      (level == LV_TWENTY) |=> (level == LV_FIVE)); // R6

   AST_IGNORE_COIN: assert property (@(posedge clk) disable iff (rst)
      (level == LV_FIFTEEN) |=> (level == LV_ZERO)); // R7

   AST_HOLD_CREDIT: assert property (@(posedge clk) disable iff (rst)
      (!nick_p && !dime_p && !release_o) |=> $stable(level)); // R8

endmodule

bind coin_vend_ctrl coin_vend_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .release_o (release_o),
   .nick_p    (nick_pulse),
   .dime_p    (dime_pulse),
   .level     (level)
);

// File: tb/test_coin_vend_ctrl.sv
`timescale 1ns/1ps
module test_coin_vend_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sn  = 1'b0;
   logic       sd  = 1'b0;
   logic [1:0] zv;

   int    n_chk  = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done   = 1'b0;

   always #2.5 clk = ~clk;

   // lane 0: binary, no extra sync; lane 1: one-hot, one extra sync flop (R9)
   coin_vend_ctrl #(.EXTRA_SYNC(0), .ONE_HOT(1'b0)) i_coin_vend_ctrl (
      .clk(clk), .rst(rst), .coin_nickel_sense(sn), .coin_dime_sense(sd),
      .release_o(zv[0]));
   coin_vend_ctrl #(.EXTRA_SYNC(1), .ONE_HOT(1'b1)) i_coin_vend_ctrl_oh (
      .clk(clk), .rst(rst), .coin_nickel_sense(sn), .coin_dime_sense(sd),
      .release_o(zv[1]));

   task automatic check(string req, logic ok, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // behavioural reference: credit in units, sense history per lane
   int         credit[2];
   logic [3:0] hn[2];
   logic [3:0] hd[2];
   int         rel[2];
   int         base[2];
   logic [1:0] zprev;

   always @(posedge clk) begin
      for (int l = 0; l < 2; l++) begin
         if (rst) begin
            credit[l] = 0; hn[l] = '0; hd[l] = '0;
         end else begin
            logic pn, pd;
            pn = hn[l][l] & ~hn[l][l+1];
            pd = hd[l][l] & ~hd[l][l+1];
            if (credit[l] >= 15) credit[l] = credit[l] - 15;
            else if (pd)         credit[l] = credit[l] + 10;
            else if (pn)         credit[l] = credit[l] + 5;
            hn[l] = {hn[l][2:0], sn};
            hd[l] = {hd[l][2:0], sd};
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         for (int l = 0; l < 2; l++) begin
            check(cur_req, zv[l] == (credit[l] >= 15), int'(zv[l]), int'(credit[l] >= 15));
            if (zv[l]) rel[l] = rel[l] + 1;
            if (zv[l] && zprev[l]) check("R5", 1'b0, 2, 1);
         end
         zprev = zv;
      end else begin
         zprev = '0;
      end
   end

   task automatic coin(bit dime, int hold, int gap);
      @(negedge clk);
      if (dime) sd = 1'b1; else sn = 1'b1;
      repeat (hold) @(negedge clk);
      sd = 1'b0; sn = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   task automatic mark();
      for (int l = 0; l < 2; l++) base[l] = rel[l];
   endtask

   task automatic expect_rel(string req, int n);
      for (int l = 0; l < 2; l++) check(req, (rel[l] - base[l]) == n, rel[l] - base[l], n);
   endtask

   initial begin
      rel[0] = 0; rel[1] = 0;
      repeat (3) @(negedge clk);
      check("R1", zv == 2'b00, int'(zv), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", zv == 2'b00, int'(zv), 0);
      settle();

      cur_req = "R2"; mark();
      coin(1'b0, 12, 2); coin(1'b0, 2, 2); coin(1'b0, 5, 3); settle();
      expect_rel("R2", 1);

      cur_req = "R4"; mark();
      coin(1'b0, 2, 1); coin(1'b1, 2, 1); settle();
      expect_rel("R4", 1);
      mark();
      coin(1'b1, 3, 2); coin(1'b0, 2, 2); settle();
      expect_rel("R4", 1);

      cur_req = "R6"; mark();
      coin(1'b1, 2, 2); coin(1'b1, 2, 2); settle();
      expect_rel("R6", 1);
      coin(1'b1, 2, 2); settle();
      expect_rel("R6", 2);

      cur_req = "R8"; mark();
      coin(1'b0, 2, 2);
      repeat (60) @(negedge clk);
      expect_rel("R8", 0);
      coin(1'b1, 2, 2); settle();
      expect_rel("R8", 1);

      cur_req = "R3"; mark();
      coin(1'b1, 2, 2); settle();
      @(negedge clk); sn = 1'b1;
      @(negedge clk);
      check("R3", zv == 2'b00, int'(zv), 0);
      @(negedge clk);
      check("R3", zv[0] == 1'b1, int'(zv[0]), 1);
      check("R3", zv[1] == 1'b0, int'(zv[1]), 0);
      @(negedge clk);
      sn = 1'b0;
      check("R5", zv[0] == 1'b0, int'(zv[0]), 0);
      check("R3", zv[1] == 1'b1, int'(zv[1]), 1);
      settle();
      expect_rel("R5", 1);

      cur_req = "R7"; mark();
      coin(1'b1, 2, 2); settle();
      @(negedge clk); sn = 1'b1;
      @(negedge clk); sd = 1'b1;
      @(negedge clk); sn = 1'b0;
      @(negedge clk); sd = 1'b0;
      settle();
      expect_rel("R7", 1);
      coin(1'b0, 2, 2); coin(1'b0, 2, 2); settle();
      expect_rel("R7", 1);
      coin(1'b0, 2, 2); settle();
      expect_rel("R7", 2);

      cur_req = "R9"; mark();
      coin(1'b0, 2, 1); coin(1'b0, 3, 1); coin(1'b1, 2, 1);
      coin(1'b0, 2, 1); coin(1'b1, 4, 1); settle();
      check("R9", rel[0] == rel[1], rel[0], rel[1]);

      cur_req = "R1";
      rst = 1'b1; sn = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", zv == 2'b00, int'(zv), 0);
      sn = 1'b0;
      rst = 1'b0;
      settle();
      check("R1", zv == 2'b00, int'(zv), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule